// File: doc/BRIEF.md
# Clock-Stop Power State Controller

This block sequences the low-power states of one processor core. A stop-clock request, followed by the response strobe of the acknowledge cycle, takes the core from its running state into a clock-stopped grant state after a fixed, parameterized number of cycles. Releasing the request brings the core back. A halt request takes the core into a halted state instead. While the core sits in either low-power state, bus snoops cause a short excursion into a matching snoop state. The controller returns to the state it came from once the snoop completes or a bus interrupt has been captured.

Five sideband events are captured while clocks are stopped: a bus-init event, a system-management interrupt, a soft init, and two local interrupt lines. On return to the running state, each captured event is replayed exactly once as a single-cycle service pulse, in a fixed priority order. In the clock-stopped states, a break-event output tells system logic that something is waiting. A core reset clears everything that was captured, but it does not pull the core out of the clock-stopped state.

Top module: `clkstop_top`

## Requirements
- R1: After the block reset, `pwrState` is 0 (running), and `breakPend`, `protoErr` and every service pulse are low.
- R2: The `pwrState` encoding is running=0, stop-grant=1, grant-snoop=2, halted=3, halt-snoop=4, extended-halt-snoop=5. If `ackResp` is sampled high with `stopClkReq` high in state 0 or 3, `pwrState` becomes 1 exactly `ENTRY_DLY` clock edges later. `ENTRY_DLY` ranges from 1 to 20.
- R3: If `stopClkReq` falls while `pwrState` is neither 1 nor 2, `protoErr` is high in that cycle and any pending entry is abandoned. A fall in state 1 or 2 does not raise `protoErr`.
- R4: In state 1 with `stopClkReq` low and no snoop, the next edge moves `pwrState` to 0.
- R5: A `coreReset` in state 1 discards all captured events and bus interrupts. `pwrState` stays 1 for as long as `stopClkReq` stays high.
- R6: Events are captured in every state, but no service pulse is issued while `pwrState` is not 0.
- R7: In state 0, captured events produce one pulse per cycle, starting in the first cycle after return. The priority order is bus-init, system-management, init, local line 0, local line 1. Each event pulses once, however many times it fired.
- R8: `snoopActive` in state 1 moves the state to 2. `snoopDone` or `busIntLatched` in state 2 returns it to 1.
- R9: `snoopActive` in state 3 moves the state to 4 when `extHaltEn` is 0, and to 5 when it is 1. `snoopDone` or `busIntLatched` in state 4 or 5 returns it to 3.
- R10: `breakPend` is high in states 1 and 2 whenever a captured event or bus interrupt is pending, and low in every other state.
- R11: `haltReq` in state 0 with no entry pending moves the state to 3. A pending event or bus interrupt in state 3 returns the state to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| stopClkReq | input | 1 | Stop-clock request level |
| ackResp | input | 1 | Response-phase strobe of the stop acknowledge cycle |
| snoopActive | input | 1 | A snoop is in progress on the bus |
| snoopDone | input | 1 | The current snoop has been serviced by any agent |
| busIntLatched | input | 1 | An interrupt message was captured from the bus |
| haltReq | input | 1 | Request to enter the halted state |
| extHaltEn | input | 1 | Selects the extended halt snoop state |
| coreReset | input | 1 | Core reset, which clears captured state |
| evtBinit | input | 1 | Bus-init event |
| evtSmi | input | 1 | System-management interrupt event |
| evtInit | input | 1 | Soft init event |
| evtLint | input | LINT_W | Local interrupt lines |
| pwrState | output | 3 | Current power state code |
| breakPend | output | 1 | Pending break event while clocks are stopped |
| protoErr | output | 1 | Early release of the stop-clock request |
| svcBinit | output | 1 | Service pulse for bus-init |
| svcSmi | output | 1 | Service pulse for system-management interrupt |
| svcInit | output | 1 | Service pulse for init |
| svcLint | output | LINT_W | Service pulses for the local lines |

## Verification
A wrong state code appears on `pwrState` at the first edge after the faulty decision, because every transition is registered straight onto that output. A lost or doubled capture stays hidden while the core is stopped and shows only through `breakPend`. It becomes visible in the pulse train one to five cycles after return to state 0, as a missing, repeated or misordered service pulse. Errors in entry timing shift the arrival of state 1 by whole cycles relative to the acknowledge strobe, so the tests sample the edge before the expected arrival and the edge of the arrival itself.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL     = 3'd0,
    ST_STOPGRANT  = 3'd1,
    ST_GRANTSNOOP = 3'd2,
    ST_HALT       = 3'd3,
    ST_HALTSNOOP  = 3'd4,
    ST_XHALTSNOOP = 3'd5
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armEntry;
    logic abortEntry;
    logic finishEntry;
    logic clrLatch;
    logic svcEn;
    logic lowPwr;
    logic busIntClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopClkReq,
  input  logic        ackResp,
  input  logic        snoopActive,
  input  logic        snoopDone,
  input  logic        busIntLatched,
  input  logic        haltReq,
  input  logic        extHaltEn,
  input  logic        coreReset,
  input  logic        entryBusy,
  input  logic        entryDone,
  input  logic        anyPend,
  input  logic        reqQ,
  output pwrState_e   state,
  output ctrlStrobe_t strb,
  output logic        protoErr
);

  pwrState_e nextState;
  logic inGrant;
  logic runOrHalt;
  logic snoopEnd;

  assign inGrant   = (state == ST_STOPGRANT) || (state == ST_GRANTSNOOP);
  assign runOrHalt = (state == ST_NORMAL) || (state == ST_HALT);
  assign snoopEnd  = snoopDone || busIntLatched;

  // release of the request outside the grant states is illegal
  assign protoErr = reqQ && !stopClkReq && !inGrant;

  always_comb begin
    strb = '0;
    strb.armEntry    = ackResp && stopClkReq && runOrHalt && !entryBusy;
    strb.abortEntry  = !stopClkReq || coreReset;
    strb.finishEntry = entryDone && stopClkReq && runOrHalt && !coreReset;
    strb.clrLatch    = coreReset;
    strb.svcEn       = (state == ST_NORMAL) && !coreReset;
    strb.lowPwr      = inGrant;
    strb.busIntClr   = (state == ST_NORMAL);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_NORMAL: begin
        if (strb.finishEntry)            nextState = ST_STOPGRANT;
        else if (coreReset)              nextState = ST_NORMAL;
        else if (haltReq && !entryBusy)  nextState = ST_HALT;
      end
      ST_HALT: begin
        if (coreReset)                   nextState = ST_NORMAL;
        else if (strb.finishEntry)       nextState = ST_STOPGRANT;
        else if (snoopActive)            nextState = extHaltEn ? ST_XHALTSNOOP : ST_HALTSNOOP;
        else if (anyPend)                nextState = ST_NORMAL;
      end
      ST_STOPGRANT: begin
        if (snoopActive)                 nextState = ST_GRANTSNOOP;
        else if (!stopClkReq)            nextState = ST_NORMAL;
      end
      ST_GRANTSNOOP: begin
        if (snoopEnd)                    nextState = ST_STOPGRANT;
      end
      ST_HALTSNOOP, ST_XHALTSNOOP: begin
        if (coreReset)                   nextState = ST_NORMAL;
        else if (snoopEnd)               nextState = ST_HALT;
      end
      default:                           nextState = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= nextState;
  end

endmodule

// File: rtl/clkstop_dp.sv
module clkstop_dp
  import clkstop_pkg::*;
#(
  parameter int ENTRY_DLY = 4,
  parameter int NUM_EVT   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic               busIntLatched,
  input  logic               stopClkReq,
  output logic               entryBusy,
  output logic               entryDone,
  output logic               anyPend,
  output logic               reqQ,
  output logic               breakPend,
  output logic [NUM_EVT-1:0] svcVec
);

  localparam int CNT_W = (ENTRY_DLY < 2) ? 1 : $clog2(ENTRY_DLY + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ENTRY_DLY - 1);

  logic [NUM_EVT-1:0] evtLat;
  logic [NUM_EVT-1:0] grant;
  logic [CNT_W-1:0]   cnt;
  logic               busIntPend;

  // lowest index wins: bit 0 has the highest priority
  always_comb begin
    grant = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (evtLat[i]) grant = NUM_EVT'(1) << i;
    end
    if (!strb.svcEn) grant = '0;
  end

  generate
    for (genvar g = 0; g < NUM_EVT; g++) begin : gLatch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              evtLat[g] <= 1'b0;
        else if (strb.clrLatch) evtLat[g] <= 1'b0;
        else if (evtVec[g])     evtLat[g] <= 1'b1;
        else if (grant[g])      evtLat[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                busIntPend <= 1'b0;
    else if (strb.clrLatch || strb.busIntClr) busIntPend <= 1'b0;
    else if (busIntLatched)                   busIntPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryBusy <= 1'b0;
      cnt       <= '0;
    end else if (strb.abortEntry || strb.finishEntry) begin
      entryBusy <= 1'b0;
      cnt       <= '0;
    end else if (strb.armEntry) begin
      entryBusy <= 1'b1;
      cnt       <= LOAD_VAL;
    end else if (entryBusy && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= stopClkReq;
  end

  assign entryDone = entryBusy && (cnt == '0);
  assign anyPend   = (|evtLat) || busIntPend;
  assign breakPend = strb.lowPwr && anyPend;
  assign svcVec    = grant;

endmodule

// File: rtl/clkstop_top.sv
module clkstop_top
  import clkstop_pkg::*;
#(
  parameter int ENTRY_DLY = 4,
  parameter int LINT_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopClkReq,
  input  logic              ackResp,
  input  logic              snoopActive,
  input  logic              snoopDone,
  input  logic              busIntLatched,
  input  logic              haltReq,
  input  logic              extHaltEn,
  input  logic              coreReset,
  input  logic              evtBinit,
  input  logic              evtSmi,
  input  logic              evtInit,
  input  logic [LINT_W-1:0] evtLint,
  output logic [2:0]        pwrState,
  output logic              breakPend,
  output logic              protoErr,
  output logic              svcBinit,
  output logic              svcSmi,
  output logic              svcInit,
  output logic [LINT_W-1:0] svcLint
);

  localparam int NUM_EVT = 3 + LINT_W;

  pwrState_e          state;
  ctrlStrobe_t        strb;
  logic               entryBusy;
  logic               entryDone;
  logic               anyPend;
  logic               reqQ;
  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_EVT-1:0] svcVec;

  assign evtVec = {evtLint, evtInit, evtSmi, evtBinit};

  clkstop_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .stopClkReq(stopClkReq), .ackResp(ackResp),
    .snoopActive(snoopActive), .snoopDone(snoopDone),
    .busIntLatched(busIntLatched), .haltReq(haltReq), .extHaltEn(extHaltEn),
    .coreReset(coreReset), .entryBusy(entryBusy), .entryDone(entryDone),
    .anyPend(anyPend), .reqQ(reqQ), .state(state), .strb(strb),
    .protoErr(protoErr)
  );

  clkstop_dp #(.ENTRY_DLY(ENTRY_DLY), .NUM_EVT(NUM_EVT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .evtVec(evtVec),
    .busIntLatched(busIntLatched), .stopClkReq(stopClkReq),
    .entryBusy(entryBusy), .entryDone(entryDone), .anyPend(anyPend),
    .reqQ(reqQ), .breakPend(breakPend), .svcVec(svcVec)
  );

  assign pwrState = state;
  assign svcBinit = svcVec[0];
  assign svcSmi   = svcVec[1];
  assign svcInit  = svcVec[2];
  assign svcLint  = svcVec[NUM_EVT-1:3];

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int ENTRY_DLY = 4,
  parameter int LINT_W    = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopClkReq,
  input logic              snoopActive,
  input logic              snoopDone,
  input logic              busIntLatched,
  input logic              coreReset,
  input logic [2:0]        pwrState,
  input logic              breakPend,
  input logic              protoErr,
  input logic              svcBinit,
  input logic              svcSmi,
  input logic              svcInit,
  input logic [LINT_W-1:0] svcLint
);

  logic [LINT_W+2:0] svcAll;
  assign svcAll = {svcLint, svcInit, svcSmi, svcBinit};

  // R2
  initial entry_range_chk: assert (ENTRY_DLY >= 1 && ENTRY_DLY <= 20);

  // R3
  err_needs_prior_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(stopClkReq));

  // R4
  sg_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd1 && !stopClkReq && !snoopActive) |=> pwrState == 3'd0);

  // R6
  svc_only_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|svcAll) |-> pwrState == 3'd0);

  // R7
  svc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(svcAll));

  // R8
  gs_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd2 && (snoopDone || busIntLatched)) |=> pwrState == 3'd1);

  // R9
  hs_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrState == 3'd4 || pwrState == 3'd5) && (snoopDone || busIntLatched) && !coreReset)
      |=> pwrState == 3'd3);

  // R10
  pbe_lowpwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakPend |-> (pwrState == 3'd1 || pwrState == 3'd2));

endmodule

bind clkstop_top clkstop_chk #(.ENTRY_DLY(ENTRY_DLY), .LINT_W(LINT_W)) chk_i (
  .clk(clk), .rstN(rstN), .stopClkReq(stopClkReq), .snoopActive(snoopActive),
  .snoopDone(snoopDone), .busIntLatched(busIntLatched), .coreReset(coreReset),
  .pwrState(pwrState), .breakPend(breakPend), .protoErr(protoErr),
  .svcBinit(svcBinit), .svcSmi(svcSmi), .svcInit(svcInit), .svcLint(svcLint)
);

// File: tb/clkstop_top_tb_top.sv
`timescale 1ns/1ps
module clkstop_top_tb_top;

  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rstN, stopClkReq, ackResp, snoopActive, snoopDone, busIntLatched;
  logic haltReq, extHaltEn, coreReset, evtBinit, evtSmi, evtInit;
  logic [1:0] evtLint;
  logic [2:0] pwrState;
  logic breakPend, protoErr, svcBinit, svcSmi, svcInit;
  logic [1:0] svcLint;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkstop_top #(.ENTRY_DLY(DLY), .LINT_W(2)) dut_i (
    .clk(clk), .rstN(rstN), .stopClkReq(stopClkReq), .ackResp(ackResp),
    .snoopActive(snoopActive), .snoopDone(snoopDone),
    .busIntLatched(busIntLatched), .haltReq(haltReq), .extHaltEn(extHaltEn),
    .coreReset(coreReset), .evtBinit(evtBinit), .evtSmi(evtSmi),
    .evtInit(evtInit), .evtLint(evtLint), .pwrState(pwrState),
    .breakPend(breakPend), .protoErr(protoErr), .svcBinit(svcBinit),
    .svcSmi(svcSmi), .svcInit(svcInit), .svcLint(svcLint)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int svcCode();
    return {svcLint, svcInit, svcSmi, svcBinit};
  endfunction

  task automatic enterSG(input string req);
    stopClkReq = 1'b1;
    ackResp = 1'b1;
    step();
    ackResp = 1'b0;
    repeat (DLY - 1) step();
    chk({req, " still running one edge early"}, pwrState, 0);
    step();
    chk({req, " stop-grant on time"}, pwrState, 1);
  endtask

  task automatic testReset();
    chk("R1 state", pwrState, 0);
    chk("R1 breakPend", breakPend, 0);
    chk("R1 protoErr", protoErr, 0);
    chk("R1 service pulses", svcCode(), 0);
  endtask

  task automatic testReplay();
    enterSG("R2");
    evtSmi = 1'b1; step(); evtSmi = 1'b0; step();
    evtSmi = 1'b1; step(); evtSmi = 1'b0;
    evtLint = 2'b10; step(); evtLint = 2'b00;
    evtBinit = 1'b1; step(); evtBinit = 1'b0;
    chk("R6 no pulse while stopped", svcCode(), 0);
    chk("R10 breakPend on capture", breakPend, 1);
    chk("R6 still stop-grant", pwrState, 1);
    stopClkReq = 1'b0;
    #1;
    chk("R3 legal release no error", protoErr, 0);
    step();
    chk("R4 back to running", pwrState, 0);
    chk("R10 breakPend low when running", breakPend, 0);
    chk("R7 first pulse bus-init", svcCode(), 5'b00001);
    step();
    chk("R7 second pulse smi once", svcCode(), 5'b00010);
    step();
    chk("R7 third pulse local line 1", svcCode(), 5'b10000);
    step();
    chk("R7 replay finished", svcCode(), 0);
  endtask

  task automatic testEarlyRelease();
    stopClkReq = 1'b1;
    ackResp = 1'b1;
    step();
    ackResp = 1'b0;
    step();
    stopClkReq = 1'b0;
    #1;
    chk("R3 early release flagged", protoErr, 1);
    step();
    chk("R3 error one cycle", protoErr, 0);
    repeat (DLY + 2) step();
    chk("R3 entry abandoned", pwrState, 0);
  endtask

  task automatic testCoreReset();
    enterSG("R2 second entry");
    evtInit = 1'b1; step(); evtInit = 1'b0;
    chk("R10 breakPend set", breakPend, 1);
    coreReset = 1'b1; step(); coreReset = 1'b0;
    chk("R5 stays stop-grant", pwrState, 1);
    chk("R5 captures discarded", breakPend, 0);
    step();
    chk("R5 still stop-grant", pwrState, 1);
    stopClkReq = 1'b0;
    step();
    chk("R5 release to running", pwrState, 0);
    chk("R5 no replay after reset", svcCode(), 0);
    step();
    chk("R5 still no replay", svcCode(), 0);
  endtask

  task automatic testGrantSnoop();
    enterSG("R2 third entry");
    snoopActive = 1'b1; step(); snoopActive = 1'b0;
    chk("R8 grant snoop", pwrState, 2);
    step();
    chk("R8 waits for done", pwrState, 2);
    snoopDone = 1'b1; step(); snoopDone = 1'b0;
    chk("R8 back after done", pwrState, 1);
    snoopActive = 1'b1; step(); snoopActive = 1'b0;
    busIntLatched = 1'b1; step(); busIntLatched = 1'b0;
    chk("R8 back after interrupt", pwrState, 1);
    chk("R10 bus interrupt raises breakPend", breakPend, 1);
    stopClkReq = 1'b0; step();
    chk("R4 running again", pwrState, 0);
    chk("R10 breakPend cleared", breakPend, 0);
  endtask

  task automatic testHalt();
    haltReq = 1'b1; step(); haltReq = 1'b0;
    chk("R11 halted", pwrState, 3);
    extHaltEn = 1'b0;
    snoopActive = 1'b1; step(); snoopActive = 1'b0;
    chk("R9 halt snoop", pwrState, 4);
    snoopDone = 1'b1; step(); snoopDone = 1'b0;
    chk("R9 back to halted", pwrState, 3);
    extHaltEn = 1'b1;
    snoopActive = 1'b1; step(); snoopActive = 1'b0;
    chk("R9 extended halt snoop", pwrState, 5);
    snoopDone = 1'b1; step(); snoopDone = 1'b0;
    extHaltEn = 1'b0;
    chk("R9 back to halted again", pwrState, 3);
    evtInit = 1'b1; step(); evtInit = 1'b0;
    chk("R11 still halted on capture edge", pwrState, 3);
    step();
    chk("R11 pending event wakes", pwrState, 0);
    chk("R7 init pulse after wake", svcCode(), 5'b00100);
    step();
    chk("R7 init pulse once", svcCode(), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; stopClkReq = 1'b0; ackResp = 1'b0; snoopActive = 1'b0;
    snoopDone = 1'b0; busIntLatched = 1'b0; haltReq = 1'b0; extHaltEn = 1'b0;
    coreReset = 1'b0; evtBinit = 1'b0; evtSmi = 1'b0; evtInit = 1'b0;
    evtLint = 2'b00;
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testReplay();
    testEarlyRelease();
    testCoreReset();
    testGrantSnoop();
    testHalt();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule